// File: doc/BRIEF.md
# Tagged Command Dispatcher for Pattern Registers

This block sits between a single command master and two small pattern-holding peripherals on the same chip. The master sends a typed command word. One field of that word, the tag, names the peripheral the command is meant for, so no address decoding takes place. The dispatcher passes the operation to that peripheral and presents an idle operation to the other one. One clock later it returns the chosen peripheral's typed response to the master.

One peripheral holds a 4-bit indicator pattern and the other holds a 6-bit colour pattern. Each understands three operations: store a new pattern, report the stored pattern, or do nothing. Each operation produces a response whose code says which of the three was carried out.

Command word `cmd_i` (9 bits): bit 8 is the tag (0 = 4-bit indicator peripheral, 1 = 6-bit colour peripheral). Bits 7:6 are the operation (00 idle, 01 write, 10 read, 11 reserved). Bits 5:0 are the data. Response word `rsp_o` (8 bits): bits 7:6 are the code (00 idle, 01 write accepted, 10 read data). Bits 5:0 are the data.

Top module: `tag_dispatch`

## Requirements
- R1: A command with tag 0 (cmd_i bit 8) acts only on the 4-bit indicator peripheral, and a command with tag 1 acts only on the 6-bit colour peripheral.
- R2: A write (op 01) replaces the target's stored pattern with the command data and answers with code 01 and data field 0.
- R3: A read (op 10) leaves the stored pattern unchanged and answers with code 10, carrying the stored pattern zero-extended in bits 5:0.
- R4: An idle operation (op 00) leaves both patterns unchanged and answers with code 00 and data 0.
- R5: Op code 11 behaves exactly like idle: it answers with code 00 and data 0 and changes no pattern.
- R6: A command is accepted in every cycle in which cmd_valid_i is high. rsp_valid_o is high in the cycle that follows an accepted command and low after a cycle without one. A cycle without a command changes no pattern.
- R7: The peripheral that the tag does not select keeps its pattern while the other one is written.
- R8: The indicator peripheral stores only data bits 3:0 and ignores bits 5:4. The colour peripheral stores all 6 data bits.
- R9: An active-low reset clears both patterns to zero and clears rsp_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 9 | Command word {tag, op[1:0], data[5:0]} |
| rsp_valid_o | output | 1 | Response present, one cycle after the command |
| rsp_o | output | 8 | Response word {code[1:0], data[5:0]} |

## Verification
The bench runs back-to-back commands that switch the tag on every command. A design that kept the previous cycle's selection would return the other peripheral's response. Writes of 6-bit values to the 4-bit peripheral are read back to confirm that bits 5:4 are dropped. Reserved op codes and commands with cmd_valid_i low are each followed by reads, so a design that stored data on those cycles would be caught. Resets in the middle of the run catch patterns that survive reset.

// File: rtl/tag_dispatch_pkg.sv
package tag_dispatch_pkg;
  localparam int TAG_W  = 1;
  localparam int OP_W   = 2;
  localparam int DATA_W = 6;
  localparam int CODE_W = 2;
  localparam int CMD_W  = TAG_W + OP_W + DATA_W;
  localparam int RSP_W  = CODE_W + DATA_W;
  localparam int NUM_SLV = 1 << TAG_W;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } op_e;

  typedef enum logic [CODE_W-1:0] {
    RSP_IDLE   = 2'b00,
    RSP_WR_OK  = 2'b01,
    RSP_RD_DAT = 2'b10,
    RSP_NONE   = 2'b11
  } code_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    op_e               op;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    code_e             code;
    logic [DATA_W-1:0] data;
  } rsp_t;
endpackage

// File: rtl/cmd_router.sv
module cmd_router
  import tag_dispatch_pkg::*;
(
  input  logic cmd_valid_i,
  input  cmd_t cmd_i,
  output op_e  slv_op_o [NUM_SLV]
);
  // Unselected slaves and reserved op codes see idle.
  for (genvar s = 0; s < NUM_SLV; s++) begin : g_route
    always_comb begin
      slv_op_o[s] = OP_IDLE;
      if (cmd_valid_i && (cmd_i.tag == TAG_W'(s)) &&
          (cmd_i.op == OP_WRITE || cmd_i.op == OP_READ))
        slv_op_o[s] = cmd_i.op;
    end
  end
endmodule

// File: rtl/pattern_reg.sv
module pattern_reg
  import tag_dispatch_pkg::*;
#(
  parameter int PAT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rsp_t              rsp_o
);
  logic [PAT_W-1:0] pat_q;
  rsp_t             rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q <= '0;
      rsp_q <= '0;
    end else begin
      unique case (op_i)
        OP_WRITE: begin
          pat_q      <= wdata_i[PAT_W-1:0];
          rsp_q.code <= RSP_WR_OK;
          rsp_q.data <= '0;
        end
        OP_READ: begin
          rsp_q.code <= RSP_RD_DAT;
          rsp_q.data <= DATA_W'(pat_q);
        end
        default: rsp_q <= '0;
      endcase
    end
  end

  assign rsp_o = rsp_q;

  p_write_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_WRITE |=> pat_q == $past(wdata_i[PAT_W-1:0]) && rsp_q.code == RSP_WR_OK);

  p_read_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_READ |=> $stable(pat_q) && rsp_q.code == RSP_RD_DAT && rsp_q.data == DATA_W'(pat_q));

  p_idle_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_IDLE |=> $stable(pat_q) && rsp_q == '0);
endmodule

// File: rtl/rsp_select.sv
module rsp_select
  import tag_dispatch_pkg::*;
(
  input  rsp_t             slv_rsp_i [NUM_SLV],
  input  logic [TAG_W-1:0] sel_i,
  output rsp_t             rsp_o
);
  always_comb begin
    rsp_o = '0;
    for (int s = 0; s < NUM_SLV; s++)
      if (sel_i == TAG_W'(s)) rsp_o = slv_rsp_i[s];
  end
endmodule

// File: rtl/tag_dispatch.sv
module tag_dispatch
  import tag_dispatch_pkg::*;
#(
  parameter int LED_W = 4,
  parameter int RGB_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             rsp_valid_o,
  output logic [RSP_W-1:0] rsp_o
);
  cmd_t             cmd;
  op_e              slv_op  [NUM_SLV];
  rsp_t             slv_rsp [NUM_SLV];
  rsp_t             rsp_sel;
  logic [TAG_W-1:0] sel_q;
  logic             valid_q;

  assign cmd = cmd_t'(cmd_i);

  cmd_router u_router (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd),
    .slv_op_o    (slv_op)
  );

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
    localparam int W = (s == 0) ? LED_W : RGB_W;
    pattern_reg #(.PAT_W(W)) u_pat (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (slv_op[s]),
      .wdata_i (cmd.data),
      .rsp_o   (slv_rsp[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      valid_q <= cmd_valid_i;
      if (cmd_valid_i) sel_q <= cmd.tag;
    end
  end

  rsp_select u_sel (
    .slv_rsp_i (slv_rsp),
    .sel_i     (sel_q),
    .rsp_o     (rsp_sel)
  );

  assign rsp_valid_o = valid_q;
  assign rsp_o       = rsp_sel;

  p_rsp_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  p_no_rsp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  p_rsvd_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd.op == OP_RSVD |=> rsp_valid_o && rsp_o == '0);

  p_unsel_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd.tag == '0 |-> slv_op[1] == OP_IDLE);

  p_route_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd.tag == 1'b1 |-> slv_op[0] == OP_IDLE);
endmodule

// File: tb/tag_dispatch_test.sv
module tag_dispatch_test;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [8:0] cmd_i = '0;
  logic       rsp_valid_o;
  logic [7:0] rsp_o;

  int checks = 0;
  int failures = 0;
  logic [3:0] led_m;
  logic [5:0] rgb_m;

  tag_dispatch uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_o       (rsp_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [8:0] mk(input logic tag, input logic [1:0] op, input logic [5:0] d);
    return {tag, op, d};
  endfunction

  // Expected response; updates the reference patterns.
  function automatic logic [7:0] model(input logic [8:0] c);
    logic       tag = c[8];
    logic [1:0] op = c[7:6];
    logic [5:0] d = c[5:0];
    case (op)
      2'b01: begin
        if (tag) rgb_m = d; else led_m = d[3:0];
        return 8'b01_000000;
      end
      2'b10: return {2'b10, tag ? rgb_m : {2'b00, led_m}};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic send(input logic [8:0] c, input string req);
    logic [7:0] e;
    cmd_valid_i = 1'b1;
    cmd_i = c;
    e = model(c);
    @(negedge clk);
    chk(req, {rsp_valid_o, rsp_o}, {1'b1, e});
  endtask

  task automatic gap(input logic [8:0] c);
    cmd_valid_i = 1'b0;
    cmd_i = c;
    @(negedge clk);
    chk("R6 no response", {rsp_valid_o, rsp_o[7:6]}, {1'b0, rsp_o[7:6]});
  endtask

  task automatic do_reset();
    cmd_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R9 reset valid", {8'h00, rsp_valid_o}, 9'h0);
    rst_ni = 1'b1;
    led_m = '0;
    rgb_m = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    led_m = '0;
    rgb_m = '0;
    @(negedge clk);
    do_reset();
    // R9: both patterns read back as zero
    send(mk(0, 2'b10, 6'h15), "R9 led after reset");
    send(mk(1, 2'b10, 6'h2a), "R9 rgb after reset");
    // R2/R8: 6-bit write into 4-bit peripheral
    send(mk(0, 2'b01, 6'h3f), "R2 led write ack");
    send(mk(0, 2'b10, 6'h00), "R8 led drops bits 5:4");
    send(mk(1, 2'b01, 6'h2a), "R2 rgb write ack");
    send(mk(1, 2'b10, 6'h00), "R8 rgb keeps 6 bits");
    // R7: writing one peripheral leaves the other intact
    send(mk(0, 2'b01, 6'h05), "R7 led write");
    send(mk(1, 2'b10, 6'h00), "R7 rgb unchanged");
    send(mk(1, 2'b01, 6'h11), "R7 rgb write");
    send(mk(0, 2'b10, 6'h00), "R7 led unchanged");
    // R5: reserved op behaves like idle
    send(mk(0, 2'b11, 6'h0a), "R5 rsvd on led");
    send(mk(0, 2'b10, 6'h00), "R5 led kept");
    send(mk(1, 2'b11, 6'h3c), "R5 rsvd on rgb");
    send(mk(1, 2'b10, 6'h00), "R5 rgb kept");
    // R4: idle op
    send(mk(1, 2'b00, 6'h3f), "R4 idle rsp");
    send(mk(1, 2'b10, 6'h00), "R4 rgb kept");
    // R6: cycle without a command has no effect
    gap(mk(0, 2'b01, 6'h0f));
    gap(mk(1, 2'b01, 6'h00));
    send(mk(0, 2'b10, 6'h00), "R6 led kept after gap");
    send(mk(1, 2'b10, 6'h00), "R6 rgb kept after gap");
    // R3: reads repeat without change
    send(mk(1, 2'b10, 6'h00), "R3 read repeat");
    // Random mix, tag switching back to back (R1)
    for (int i = 0; i < 400; i++) begin
      logic [8:0] c = 9'($urandom);
      if (($urandom % 8) == 0) gap(c);
      else send(c, "R1 random mix");
      if (i == 200) begin
        do_reset();
        send(mk(0, 2'b10, 6'h00), "R9 led after mid reset");
        send(mk(1, 2'b10, 6'h00), "R9 rgb after mid reset");
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule